// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox Bridge

This block joins an 8-bit host processor bus to an 8-bit controller-side bus. It holds two one-byte mailboxes. The inbound mailbox carries bytes from the host to the controller, and the outbound mailbox carries bytes from the controller to the host. Each mailbox has a full/empty state, and both sides see that state. The host side shows an output-empty flag and an input-full flag. The controller side shows the complements of those flags: input-full and output-empty.

A mode pin selects one of two host bus styles:
- Separate active-low read and write strobes, each qualified by an active-low chip select.
- A single read/write line qualified by chip select.

The controller side uses an active-high select with active-low read and write strobes. A transfer completes on the trailing edge of its strobe. That edge is seen at the first clock edge where the qualified strobe is sampled inactive, and the flags change at that same clock edge. The active-low reset empties both mailboxes and clears the error output.

The error output is active low. It falls when a write arrives at a mailbox that still holds an unread byte. It stays low until reset, and the overwriting byte is dropped. Data buses are modelled as separate input and output ports. All inputs are taken to be synchronous to the clock.

Top module: `hostMailboxBridge`

## Requirements
- R1: After reset the flags are as follows: hostOutEmpty=1, hostInFull=0, ctlInFull=0, ctlOutEmpty=1, errN=1, and both mailbox bytes read as 0x00.
- R2: With hostRwMode=0, a host write is hostCsN=0 with hostWrN=0, and a host read is hostCsN=0 with hostRdN=0. In this mode hostRwN has no effect.
- R3: With hostRwMode=1, hostCsN=0 with hostRwN=0 is a write, and hostCsN=0 with hostRwN=1 is a read. In this mode hostRdN and hostWrN have no effect.
- R4: A controller read is ctlCs=1 with ctlRdN=0, and a controller write is ctlCs=1 with ctlWrN=0. Strobes given while ctlCs=0 have no effect.
- R5: A completed host write stores the hostDin value from the last active cycle in the inbound mailbox and presents it on ctlDout. It sets ctlInFull=1 and hostOutEmpty=0.
- R6: A completed controller read clears ctlInFull to 0 and sets hostOutEmpty to 1.
- R7: A completed controller write stores ctlDin in the outbound mailbox and presents it on hostDout. It sets hostInFull=1 and ctlOutEmpty=0.
- R8: A completed host read clears hostInFull to 0 and sets ctlOutEmpty to 1.
- R9: At all times hostInFull equals the inverse of ctlOutEmpty, and hostOutEmpty equals the inverse of ctlInFull.
- R10: A write to a full mailbox does not change that mailbox. It drives errN low, and errN stays low until reset.
- R11: If a write completes in the same cycle as the read that empties the same mailbox, the write is accepted without error and the mailbox stays full with the new byte. The read returns the old byte.
- R12: A strobe held active for many cycles counts as one transfer. A read of an empty mailbox changes nothing.
- R13: Reset asserted in any state returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Parallel-interface reset, active low |
| hostRwMode | input | 1 | Host bus style: 0 = separate strobes, 1 = read/write line |
| hostCsN | input | 1 | Host chip select, active low |
| hostRdN | input | 1 | Host read strobe, active low (mode 0) |
| hostWrN | input | 1 | Host write strobe, active low (mode 0) |
| hostRwN | input | 1 | Host read/write line, 1 = read, 0 = write (mode 1) |
| hostDin | input | 8 | Host write data |
| hostDout | output | 8 | Outbound mailbox byte |
| hostOutEmpty | output | 1 | Host may write: inbound mailbox empty |
| hostInFull | output | 1 | Host may read: outbound mailbox full |
| ctlCs | input | 1 | Controller chip select, active high |
| ctlRdN | input | 1 | Controller read strobe, active low |
| ctlWrN | input | 1 | Controller write strobe, active low |
| ctlDin | input | 8 | Controller write data |
| ctlDout | output | 8 | Inbound mailbox byte |
| ctlInFull | output | 1 | Inbound mailbox holds an unread byte |
| ctlOutEmpty | output | 1 | Outbound mailbox empty |
| errN | output | 1 | Sticky overwrite error, active low |

## Verification
A write into a mailbox and the read that empties it are two separate functions, and both can complete in the same clock. The bench provokes this for each mailbox. It first fills the mailbox. Then it holds a write strobe from one side and a read strobe from the other side active together, and releases both on the same falling clock edge. While both strobes are active, the read side must still show the old byte. After release, the mailbox must stay full and hold the new byte, and errN must stay high. An overwrite with no read in the same cycle must instead drive errN low and keep the old byte.

// File: rtl/mboxPkg.sv
package mboxPkg;
  localparam int NUM_XFER = 4;

  // One bit per transfer kind; used for both active levels and completion events
  typedef struct packed {
    logic hostWr;
    logic hostRd;
    logic ctlWr;
    logic ctlRd;
  } xfer_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capHost;  // track hostDin while a host write is active
    logic capCtl;   // track ctlDin while a controller write is active
    logic loadIn;   // commit captured host byte to inbound mailbox
    logic loadOut;  // commit captured controller byte to outbound mailbox
  } dpStrobe_t;
endpackage

// File: rtl/mboxStrobeDecode.sv
module mboxStrobeDecode
  import mboxPkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  hostRwMode,
  input  logic  hostCsN,
  input  logic  hostRdN,
  input  logic  hostWrN,
  input  logic  hostRwN,
  input  logic  ctlCs,
  input  logic  ctlRdN,
  input  logic  ctlWrN,
  output xfer_t actLvl,
  output xfer_t evt
);
  logic                hostSel;
  logic [NUM_XFER-1:0] actVec;
  logic [NUM_XFER-1:0] actQ;
  logic [NUM_XFER-1:0] evtVec;

  always_comb begin
    hostSel = !hostCsN;
    if (hostRwMode) begin
      actLvl.hostWr = hostSel && !hostRwN;
      actLvl.hostRd = hostSel && hostRwN;
    end else begin
      actLvl.hostWr = hostSel && !hostWrN;
      actLvl.hostRd = hostSel && !hostRdN;
    end
    actLvl.ctlWr = ctlCs && !ctlWrN;
    actLvl.ctlRd = ctlCs && !ctlRdN;
  end

  assign actVec = actLvl;

  // Trailing-edge detector per transfer kind
  for (genvar i = 0; i < NUM_XFER; i++) begin : g_edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) actQ[i] <= 1'b0;
      else       actQ[i] <= actVec[i];
    end
    assign evtVec[i] = actQ[i] && !actVec[i];

    // R12: a completion event can never repeat on consecutive cycles
    a_r12_single_event: assert property (@(posedge clk) disable iff (!rstN)
      evtVec[i] |=> !evtVec[i]);
  end

  assign evt = evtVec;
endmodule

// File: rtl/mboxControl.sv
module mboxControl
  import mboxPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  xfer_t     actLvl,
  input  xfer_t     evt,
  output logic      inFull,
  output logic      outFull,
  output logic      errN,
  output dpStrobe_t st
);
  logic inAccept, outAccept, inOver, outOver;

  always_comb begin
    inAccept  = evt.hostWr && (!inFull  || evt.ctlRd);
    outAccept = evt.ctlWr  && (!outFull || evt.hostRd);
    inOver    = evt.hostWr && inFull  && !evt.ctlRd;
    outOver   = evt.ctlWr  && outFull && !evt.hostRd;
    st.capHost = actLvl.hostWr;
    st.capCtl  = actLvl.ctlWr;
    st.loadIn  = inAccept;
    st.loadOut = outAccept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFull  <= 1'b0;
      outFull <= 1'b0;
      errN    <= 1'b1;
    end else begin
      if (inAccept)       inFull <= 1'b1;
      else if (evt.ctlRd) inFull <= 1'b0;
      if (outAccept)       outFull <= 1'b1;
      else if (evt.hostRd) outFull <= 1'b0;
      if (inOver || outOver) errN <= 1'b0;
    end
  end

  a_r5_write_fills_in: assert property (@(posedge clk) disable iff (!rstN)
    evt.hostWr |=> inFull);
  a_r6_read_empties_in: assert property (@(posedge clk) disable iff (!rstN)
    (evt.ctlRd && !evt.hostWr) |=> !inFull);
  a_r7_write_fills_out: assert property (@(posedge clk) disable iff (!rstN)
    evt.ctlWr |=> outFull);
  a_r8_read_empties_out: assert property (@(posedge clk) disable iff (!rstN)
    (evt.hostRd && !evt.ctlWr) |=> !outFull);
  a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !errN |=> !errN);
  a_r10_overwrite_flags: assert property (@(posedge clk) disable iff (!rstN)
    ((evt.hostWr && inFull && !evt.ctlRd) || (evt.ctlWr && outFull && !evt.hostRd)) |=> !errN);
  a_r11_same_cycle_ok: assert property (@(posedge clk) disable iff (!rstN)
    (errN && evt.hostWr && evt.ctlRd && !evt.ctlWr) |=> errN);
endmodule

// File: rtl/mboxData.sv
module mboxData
  import mboxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [DATA_W-1:0] hostDin,
  input  logic [DATA_W-1:0] ctlDin,
  output logic [DATA_W-1:0] inByte,
  output logic [DATA_W-1:0] outByte
);
  logic [DATA_W-1:0] hostCap, ctlCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostCap <= '0;
      ctlCap  <= '0;
      inByte  <= '0;
      outByte <= '0;
    end else begin
      if (st.capHost) hostCap <= hostDin;
      if (st.capCtl)  ctlCap  <= ctlDin;
      if (st.loadIn)  inByte  <= hostCap;
      if (st.loadOut) outByte <= ctlCap;
    end
  end

  // R10: mailbox bytes move only on an accepted load
  a_r10_in_held: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadIn |=> $stable(inByte));
  a_r10_out_held: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadOut |=> $stable(outByte));
endmodule

// File: rtl/hostMailboxBridge.sv
module hostMailboxBridge
  import mboxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRwMode,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic              hostRwN,
  input  logic [DATA_W-1:0] hostDin,
  output logic [DATA_W-1:0] hostDout,
  output logic              hostOutEmpty,
  output logic              hostInFull,
  input  logic              ctlCs,
  input  logic              ctlRdN,
  input  logic              ctlWrN,
  input  logic [DATA_W-1:0] ctlDin,
  output logic [DATA_W-1:0] ctlDout,
  output logic              ctlInFull,
  output logic              ctlOutEmpty,
  output logic              errN
);
  xfer_t     actLvl, evt;
  dpStrobe_t st;
  logic      inFull, outFull;

  mboxStrobeDecode u_decode (
    .clk(clk), .rstN(rstN), .hostRwMode(hostRwMode),
    .hostCsN(hostCsN), .hostRdN(hostRdN), .hostWrN(hostWrN), .hostRwN(hostRwN),
    .ctlCs(ctlCs), .ctlRdN(ctlRdN), .ctlWrN(ctlWrN),
    .actLvl(actLvl), .evt(evt)
  );

  mboxControl u_ctrl (
    .clk(clk), .rstN(rstN), .actLvl(actLvl), .evt(evt),
    .inFull(inFull), .outFull(outFull), .errN(errN), .st(st)
  );

  mboxData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .st(st),
    .hostDin(hostDin), .ctlDin(ctlDin),
    .inByte(ctlDout), .outByte(hostDout)
  );

  assign ctlInFull    = inFull;
  assign hostOutEmpty = !inFull;
  assign hostInFull   = outFull;
  assign ctlOutEmpty  = !outFull;
endmodule

// File: tb/hostMailboxBridge_tb.sv
module hostMailboxBridge_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostRwMode = 1'b0;
  logic       hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1, hostRwN = 1'b1;
  logic [7:0] hostDin = '0, ctlDin = '0;
  logic       ctlCs = 1'b0, ctlRdN = 1'b1, ctlWrN = 1'b1;
  logic [7:0] hostDout, ctlDout;
  logic       hostOutEmpty, hostInFull, ctlInFull, ctlOutEmpty, errN;
  int         errors = 0;
  int         checks = 0;

  always #4 clk = ~clk;

  hostMailboxBridge u_dut (
    .clk(clk), .rstN(rstN), .hostRwMode(hostRwMode),
    .hostCsN(hostCsN), .hostRdN(hostRdN), .hostWrN(hostWrN), .hostRwN(hostRwN),
    .hostDin(hostDin), .hostDout(hostDout), .hostOutEmpty(hostOutEmpty), .hostInFull(hostInFull),
    .ctlCs(ctlCs), .ctlRdN(ctlRdN), .ctlWrN(ctlWrN), .ctlDin(ctlDin),
    .ctlDout(ctlDout), .ctlInFull(ctlInFull), .ctlOutEmpty(ctlOutEmpty), .errN(errN)
  );

  // op codes: 0 host write, 1 host read, 2 controller write, 3 controller read
  // layout: op[29:28] mode[27] data[26:19] eHIF[18] eHOE[17] eErrN[16] eIn[15:8] eOut[7:0]
  localparam int NV = 12;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h00},
    {2'd3, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h00},
    {2'd2, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h3C},
    {2'd1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h3C},
    {2'd0, 1'b1, 8'h96, 1'b0, 1'b0, 1'b1, 8'h96, 8'h3C},
    {2'd3, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h96, 8'h3C},
    {2'd2, 1'b1, 8'hC3, 1'b1, 1'b1, 1'b1, 8'h96, 8'hC3},
    {2'd1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h96, 8'hC3},
    {2'd1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h96, 8'hC3},
    {2'd3, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h96, 8'hC3},
    {2'd2, 1'b0, 8'h11, 1'b1, 1'b1, 1'b1, 8'h96, 8'h11},
    {2'd0, 1'b1, 8'h22, 1'b1, 1'b0, 1'b1, 8'h22, 8'h11}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flags packed as {hostInFull, hostOutEmpty, ctlInFull, ctlOutEmpty, errN}; R9 complements built in
  task automatic checkFlags(input string tag, input logic eHif, input logic eHoe, input logic eErr);
    check(tag, {27'd0, hostInFull, hostOutEmpty, ctlInFull, ctlOutEmpty, errN},
               {27'd0, eHif, eHoe, !eHoe, !eHif, eErr});
  endtask

  task automatic checkData(input string tag, input logic [7:0] eIn, input logic [7:0] eOut);
    check(tag, {16'd0, ctlDout, hostDout}, {16'd0, eIn, eOut});
  endtask

  task automatic setOp(input logic [1:0] op, input logic mode, input logic [7:0] d, input logic on);
    hostRwMode = mode;
    case (op)
      2'd0: begin
        hostDin = d;
        hostCsN = !on;
        if (mode) hostRwN = !on; else hostWrN = !on;
      end
      2'd1: begin
        hostCsN = !on;
        if (mode) hostRwN = 1'b1; else hostRdN = !on;
      end
      2'd2: begin ctlDin = d; ctlCs = on; ctlWrN = !on; end
      default: begin ctlCs = on; ctlRdN = !on; end
    endcase
    if (!on) begin
      hostCsN = 1'b1; hostRdN = 1'b1; hostWrN = 1'b1; hostRwN = 1'b1;
      ctlCs = 1'b0; ctlRdN = 1'b1; ctlWrN = 1'b1;
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the completion clock
  task automatic doOp(input logic [1:0] op, input logic mode, input logic [7:0] d, input int hold);
    setOp(op, mode, d, 1'b1);
    repeat (hold) @(negedge clk);
    setOp(op, mode, d, 1'b0);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkFlags("R1 reset flags", 1'b0, 1'b1, 1'b1);
    checkData("R1 reset data", 8'h00, 8'h00);

    // Vector table: R2/R3 modes, R5..R9, R12 empty reads
    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      string tag;
      v = VEC[i];
      case (v[29:28])
        2'd0: tag = v[27] ? "R3 R5 host write" : "R2 R5 host write";
        2'd1: tag = v[27] ? "R3 R8 host read" : "R2 R8 R12 host read";
        2'd2: tag = "R4 R7 ctl write";
        default: tag = "R6 R9 R12 ctl read";
      endcase
      doOp(v[29:28], v[27], v[26:19], 2);
      checkFlags(tag, v[18], v[17], v[16]);
      checkData(tag, v[15:8], v[7:0]);
    end

    // R11: host write and controller read of full inbound complete together
    setOp(2'd0, 1'b0, 8'h66, 1'b1);
    setOp(2'd3, 1'b0, 8'h00, 1'b1);
    @(negedge clk);
    @(negedge clk);
    check("R11 read sees old byte", {24'd0, ctlDout}, {24'd0, 8'h22});
    setOp(2'd0, 1'b0, 8'h66, 1'b0);
    @(negedge clk);
    checkFlags("R11 inbound stays full", 1'b1, 1'b0, 1'b1);
    check("R11 inbound new byte", {24'd0, ctlDout}, {24'd0, 8'h66});

    // R11: controller write and host read of full outbound complete together
    setOp(2'd2, 1'b0, 8'h77, 1'b1);
    setOp(2'd1, 1'b1, 8'h00, 1'b1);
    @(negedge clk);
    @(negedge clk);
    check("R11 host read sees old byte", {24'd0, hostDout}, {24'd0, 8'h11});
    setOp(2'd2, 1'b0, 8'h00, 1'b0);
    @(negedge clk);
    checkFlags("R11 outbound stays full", 1'b1, 1'b0, 1'b1);
    check("R11 outbound new byte", {24'd0, hostDout}, {24'd0, 8'h77});

    // drain both
    doOp(2'd3, 1'b0, 8'h00, 1);
    doOp(2'd1, 1'b0, 8'h00, 1);
    checkFlags("R6 R8 drained", 1'b0, 1'b1, 1'b1);

    // R4: controller strobes without select are ignored
    ctlDin = 8'hEE; ctlWrN = 1'b0; ctlRdN = 1'b0;
    repeat (2) @(negedge clk);
    ctlWrN = 1'b1; ctlRdN = 1'b1;
    @(negedge clk);
    checkFlags("R4 ctl unselected", 1'b0, 1'b1, 1'b1);
    check("R4 out byte unchanged", {24'd0, hostDout}, {24'd0, 8'h77});

    // R3: strobe pins ignored in read/write-line mode, select high
    hostRwMode = 1'b1; hostDin = 8'hDD; hostWrN = 1'b0;
    repeat (2) @(negedge clk);
    hostCsN = 1'b0; hostRwN = 1'b1; hostWrN = 1'b0;  // read-line high -> read of empty, no write
    repeat (2) @(negedge clk);
    hostCsN = 1'b1; hostWrN = 1'b1;
    @(negedge clk);
    checkFlags("R3 strobe pins ignored", 1'b0, 1'b1, 1'b1);
    check("R3 in byte unchanged", {24'd0, ctlDout}, {24'd0, 8'h66});

    // R2: read/write line ignored in strobe mode
    hostRwMode = 1'b0; hostCsN = 1'b0; hostRwN = 1'b0;
    repeat (2) @(negedge clk);
    hostCsN = 1'b1; hostRwN = 1'b1;
    @(negedge clk);
    checkFlags("R2 rw line ignored", 1'b0, 1'b1, 1'b1);

    // R12: long strobes count once
    doOp(2'd0, 1'b0, 8'h5A, 10);
    checkFlags("R12 long write once", 1'b0, 1'b0, 1'b1);
    doOp(2'd3, 1'b0, 8'h00, 10);
    checkFlags("R12 long read once", 1'b0, 1'b1, 1'b1);
    check("R12 byte", {24'd0, ctlDout}, {24'd0, 8'h5A});

    // R10: inbound overwrite
    doOp(2'd0, 1'b0, 8'h81, 2);
    doOp(2'd0, 1'b1, 8'h82, 2);
    checkFlags("R10 inbound overwrite", 1'b0, 1'b0, 1'b0);
    check("R10 byte discarded", {24'd0, ctlDout}, {24'd0, 8'h81});
    doOp(2'd3, 1'b0, 8'h00, 2);
    checkFlags("R10 error sticky", 1'b0, 1'b1, 1'b0);

    // R13: reset from error state
    doReset();
    checkFlags("R13 reset flags", 1'b0, 1'b1, 1'b1);
    checkData("R13 reset data", 8'h00, 8'h00);

    // R10: outbound overwrite
    doOp(2'd2, 1'b0, 8'h91, 2);
    doOp(2'd2, 1'b0, 8'h92, 2);
    checkFlags("R10 outbound overwrite", 1'b1, 1'b1, 1'b0);
    check("R10 out byte discarded", {24'd0, hostDout}, {24'd0, 8'h91});

    doReset();
    checkFlags("R13 second reset", 1'b0, 1'b1, 1'b1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule